// File: doc/BRIEF.md
# USB PHY Clock Control Register

This block is one configuration register for the clocks of two USB PHYs: a high-speed PHY that has its own PLL, and a full-speed PHY. Software writes the register through a write port with a per-bit mask, so one write can change any chosen set of fields and leave the others alone. The register holds two clock-source selects, a reference-frequency code, and the PHY reset, power-down and PLL-on controls.

A behavioural model of the high-speed PHY PLL stands behind the register. It raises a clock-good status bit a fixed number of cycles after it is started. It locks only while the USB 2.0 subsystem module enable (`mod_en_i`) is high. Once clock-good is up, that enable can be removed and the lock is kept.

The block also exposes its decoded state. This includes the meaning of each select, the reference rate in kHz, and the PLL output rate.

Top module: `usb_phy_clk_ctrl`

Control word layout (read and write): bit 0 `hs_sel`, bit 1 `fs_sel`, bits 5:2 `ref_code`, bit 6 `phy_rst`, bit 7 `phy_pdn`, bit 8 `pll_on`, bit 9 `clk_good` (read-only), bits 15:10 read as zero.

## Requirements
- R1: After reset the control word reads 0x00C0: reset and power-down set, PLL off, both selects 0, code 0, clock-good low.
- R2: A write changes exactly the writable bits (8:0) whose mask bit is 1. Bits 15:9 ignore writes, and a write with an all-zero mask changes nothing.
- R3: High-speed select bit 0 = 0 picks the external reference (`hs_use_aux_o` = 0); bit 0 = 1 picks the auxiliary bypass clock (`hs_use_aux_o` = 1).
- R4: The full-speed select has the opposite polarity. Bit 1 = 1 picks the external reference (`fs_use_ext_o` = 1); bit 1 = 0 picks the high-speed PHY PLL output (`fs_use_ext_o` = 0).
- R5: The reference code maps 0..8 to 12000, 13000, 19200, 20000, 24000, 26000, 38400, 40000 and 48000 kHz on `ref_khz_o`. Codes 9..15 give 0.
- R6: The PLL runs when `pll_on` is 1, `phy_rst` and `phy_pdn` are 0, and the code is legal. With the PLL running and `mod_en_i` high, clock-good rises exactly LOCK_CYCLES clock edges after the edge that started the run.
- R7: While clock-good is low, a low `mod_en_i` clears the lock count. Clock-good cannot rise while `mod_en_i` is low.
- R8: Once clock-good is high, it stays high with `mod_en_i` low for as long as the run condition holds.
- R9: If the run condition fails (power-down set, reset set, PLL off, or illegal code), clock-good is low after the next clock edge.
- R10: `pll_khz_o` is 48000 whenever clock-good is high, whatever the legal code is, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| wr_mask_i | input | 16 | Per-bit write mask, 1 = update |
| mod_en_i | input | 1 | USB 2.0 subsystem module enable, needed for lock |
| rd_data_o | output | 16 | Control word with live clock-good |
| clk_good_o | output | 1 | PLL clock-good status |
| hs_use_aux_o | output | 1 | High-speed PHY uses the auxiliary bypass clock |
| fs_use_ext_o | output | 1 | Full-speed PHY uses the external reference |
| ref_khz_o | output | 16 | Decoded reference rate in kHz, 0 if illegal |
| pll_khz_o | output | 16 | PLL output rate in kHz, 0 while unlocked |

## Verification
The masked write is tried with three kinds of write:
- single-bit masks, which separate the two select polarities;
- a write that targets only the read-only upper bits;
- a write with an empty mask.

All sixteen reference codes are swept, which finds the edge between legal and illegal codes. Lock is first tried with the enable held high, which pins the exact lock cycle. It is then tried with the enable low, and with the enable dropped partway through counting, which shows that the count restarts. Once locked, the enable is removed to show the lock is kept. Power-down, reset and an illegal code are then applied in turn; each must drop clock-good one edge later.

// File: rtl/usb_phy_clk_pkg.sv
package usb_phy_clk_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned RATE_W   = 16;
  localparam int unsigned HS_SEL_B = 0;
  localparam int unsigned FS_SEL_B = 1;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned RST_B    = 6;
  localparam int unsigned PDN_B    = 7;
  localparam int unsigned PLLON_B  = 8;
  localparam int unsigned GOOD_B   = 9;
  localparam int unsigned WR_BITS  = 9;   // writable bits 8:0
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(16'h00C0);
  localparam logic [RATE_W-1:0] PLL_OUT_KHZ = RATE_W'(48000);

  function automatic logic [RATE_W-1:0] code_to_khz(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:    return RATE_W'(12000);
      4'd1:    return RATE_W'(13000);
      4'd2:    return RATE_W'(19200);
      4'd3:    return RATE_W'(20000);
      4'd4:    return RATE_W'(24000);
      4'd5:    return RATE_W'(26000);
      4'd6:    return RATE_W'(38400);
      4'd7:    return RATE_W'(40000);
      4'd8:    return RATE_W'(48000);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/usb_phy_clk_regs.sv
module usb_phy_clk_regs
  import usb_phy_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic [CTRL_W-1:0] wr_mask_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [CTRL_W-1:0] WR_MASK = CTRL_W'((1 << WR_BITS) - 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] eff_mask;

  assign eff_mask = wr_mask_i & WR_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (wr_en_i) ctrl_q <= (ctrl_q & ~eff_mask) | (wr_data_i & eff_mask);
  end

  assign ctrl_o = ctrl_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctrl_q));

  assert_masked_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((ctrl_q & ~$past(wr_mask_i)) == ($past(ctrl_q) & ~$past(wr_mask_i))));
endmodule

// File: rtl/usb_phy_pll_model.sv
module usb_phy_pll_model #(
  parameter int unsigned LOCK_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic mod_en_i,
  output logic locked_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (!mod_en_i)              cnt_q <= '0;
      else if (cnt_q == CNT_LAST) locked_q <= 1'b1;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked_o = locked_q;

  assert_lock_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(mod_en_i));

  assert_lock_needs_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(run_i));

  assert_lock_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && run_i) |=> locked_q);

  assert_drop_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !locked_q);
endmodule

// File: rtl/usb_phy_clk_ctrl.sv
module usb_phy_clk_ctrl
  import usb_phy_clk_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic [15:0] wr_mask_i,
  input  logic        mod_en_i,
  output logic [15:0] rd_data_o,
  output logic        clk_good_o,
  output logic        hs_use_aux_o,
  output logic        fs_use_ext_o,
  output logic [15:0] ref_khz_o,
  output logic [15:0] pll_khz_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [CODE_W-1:0] code;
  logic [RATE_W-1:0] ref_khz;
  logic              run;
  logic              locked;

  usb_phy_clk_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_mask_i (wr_mask_i),
    .ctrl_o    (ctrl)
  );

  assign code    = ctrl[CODE_LSB +: CODE_W];
  assign ref_khz = code_to_khz(code);
  // an illegal code decodes to 0 and blocks the run
  assign run     = ctrl[PLLON_B] & ~ctrl[RST_B] & ~ctrl[PDN_B] & (ref_khz != '0);

  usb_phy_pll_model #(.LOCK_CYCLES(LOCK_CYCLES)) u_pll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .mod_en_i (mod_en_i),
    .locked_o (locked)
  );

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[8:0]    = ctrl[8:0];
    rd_data_o[GOOD_B] = locked;
  end

  assign clk_good_o   = locked;
  assign hs_use_aux_o = ctrl[HS_SEL_B];
  assign fs_use_ext_o = ctrl[FS_SEL_B];
  assign ref_khz_o    = ref_khz;
  assign pll_khz_o    = locked ? PLL_OUT_KHZ : '0;
endmodule

// File: tb/usb_phy_clk_ctrl_tb.sv
module usb_phy_clk_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] wr_mask_i = '0;
  logic        mod_en_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        clk_good_o;
  logic        hs_use_aux_o;
  logic        fs_use_ext_o;
  logic [15:0] ref_khz_o;
  logic [15:0] pll_khz_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  usb_phy_clk_ctrl #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .wr_mask_i(wr_mask_i), .mod_en_i(mod_en_i), .rd_data_o(rd_data_o),
    .clk_good_o(clk_good_o), .hs_use_aux_o(hs_use_aux_o), .fs_use_ext_o(fs_use_ext_o),
    .ref_khz_o(ref_khz_o), .pll_khz_o(pll_khz_o)
  );

  typedef struct {
    logic [15:0] rd;
    logic        good;
    logic        hs;
    logic        fs;
    logic [15:0] refk;
    logic [15:0] pllk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [8:0] sh = 9'h0C0;   // bench shadow of writable bits
  logic       good = 1'b0;

  function automatic logic [15:0] spec_khz(input logic [3:0] c);
    case (c)
      4'd0: return 16'd12000; 4'd1: return 16'd13000; 4'd2: return 16'd19200;
      4'd3: return 16'd20000; 4'd4: return 16'd24000; 4'd5: return 16'd26000;
      4'd6: return 16'd38400; 4'd7: return 16'd40000; 4'd8: return 16'd48000;
      default: return 16'd0;
    endcase
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.rd   = {6'b0, good, sh};
    e.good = good;
    e.hs   = sh[0];
    e.fs   = sh[1];
    e.refk = spec_khz(sh[5:2]);
    e.pllk = good ? 16'd48000 : 16'd0;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic do_write(input logic [15:0] d, input logic [15:0] m);
    @(posedge clk_i); #2;
    wr_en_i = 1'b1; wr_data_i = d; wr_mask_i = m;
    @(posedge clk_i); #2;
    wr_en_i = 1'b0; wr_data_i = '0; wr_mask_i = '0;
    sh = (sh & ~m[8:0]) | (d[8:0] & m[8:0]);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #2;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compare every queued expectation away from the active edge
  always @(negedge clk_i) begin
    exp_t e;
    while (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (rd_data_o !== e.rd || clk_good_o !== e.good || hs_use_aux_o !== e.hs ||
          fs_use_ext_o !== e.fs || ref_khz_o !== e.refk || pll_khz_o !== e.pllk) begin
        n_fail++;
        $display("FAIL %s: rd=%h good=%b hs=%b fs=%b ref=%0d pll=%0d expected rd=%h good=%b hs=%b fs=%b ref=%0d pll=%0d",
                 e.tag, rd_data_o, clk_good_o, hs_use_aux_o, fs_use_ext_o, ref_khz_o, pll_khz_o,
                 e.rd, e.good, e.hs, e.fs, e.refk, e.pllk);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    cycles(3);
    rst_ni = 1'b1;
    cycles(1);
    push_exp("R1 reset state");

    do_write(16'hFFFF, 16'h0003);
    push_exp("R3 R4 both selects set");
    do_write(16'h0000, 16'h0001);
    push_exp("R3 hs select back to external ref");
    do_write(16'h0000, 16'h0002);
    push_exp("R4 fs select to hs PLL");
    do_write(16'hFE00, 16'hFE00);
    push_exp("R2 read-only bits ignore write");
    do_write(16'hFFFF, 16'h0000);
    push_exp("R2 empty mask");

    for (int c = 0; c < 16; c++) begin
      do_write(16'(c << 2), 16'h003C);
      push_exp("R5 code sweep");
    end

    // lock with enable held (code 4 = 24 MHz)
    do_write(16'h0010, 16'h003C);
    mod_en_i = 1'b1;
    do_write(16'h0100, 16'h01C0);
    cycles(LOCK - 1);
    push_exp("R6 one edge before lock");
    cycles(1);
    good = 1'b1;
    push_exp("R6 R10 lock edge");

    mod_en_i = 1'b0;
    cycles(10);
    push_exp("R8 lock kept without enable");

    do_write(16'h0080, 16'h0080);
    cycles(1);
    good = 1'b0;
    push_exp("R9 power-down drops clock-good");

    do_write(16'h0000, 16'h0080);
    cycles(2 * LOCK);
    push_exp("R7 no lock while enable low");
    mod_en_i = 1'b1;
    cycles(LOCK / 2);
    mod_en_i = 1'b0;
    cycles(1);
    mod_en_i = 1'b1;
    cycles(LOCK - 1);
    push_exp("R7 count restarted after enable drop");
    cycles(1);
    good = 1'b1;
    push_exp("R7 lock after restarted count");

    do_write(16'h0020, 16'h003C);   // code 8, still legal
    cycles(1);
    push_exp("R10 rate fixed for 48 MHz reference");

    do_write(16'h0024, 16'h003C);   // code 9, illegal
    cycles(1);
    good = 1'b0;
    push_exp("R9 R5 illegal code drops clock-good");

    do_write(16'h0004, 16'h003C);   // code 1
    cycles(LOCK);
    good = 1'b1;
    push_exp("R6 relock on 13 MHz");
    do_write(16'h0040, 16'h0040);
    cycles(1);
    good = 1'b0;
    push_exp("R9 reset bit drops clock-good");

    do_write(16'h0000, 16'h0140);
    cycles(LOCK + 2);
    push_exp("R9 PLL off keeps clock-good low");

    cycles(2);
    done = 1;
    finish_run();
  end
endmodule